// File: doc/BRIEF.md
# Strobe-Sequenced Serial Memory Port

This block is the front end of a small byte-wide memory (512 locations of 8 bits) that sits on an ordinary processor bus but moves all of its information over a single data bit. The host uses three active-low strobes: select, read and write. It issues ordinary bus reads and writes to the block, and the order of those accesses carries the protocol. There is no opcode. Two patterns act as commands: a read, a write of 0, then a read resets the port. A read, a write of 1, then a read after a page load asks the downstream controller to start a nonvolatile write.

The strobes and the data bit are brought into the system clock domain through flop synchronizers. An access is counted when it ends. The block shifts in a 16-bit serial address, streams bytes out one bit per read, and collects written bits into bytes. It reports address, byte and command events as one-cycle pulses to a separate page/write controller. Read data comes from a synchronous memory port through a request/acknowledge pair.

Top module: `strobe_serial_port`

## Requirements
- R1: A write access is select and write asserted with read deasserted. A read access is select and read asserted with write deasserted. An access counts once, when it ends (its strobe or select deasserts). Strobe activity while select is deasserted has no effect.
- R2: `dq_oe` is high while select and read are both asserted, after synchronization, and low otherwise.
- R3: Read and write asserted together under select raise `illegal`. The whole access is then discarded: it shifts no bit and counts as no cycle.
- R4: A completed read, a completed write of 0 and a completed read, back to back, pulse `reset_evt` at the end of the third access. This aborts any address load, read stream or page load in progress.
- R5: After a reset, and in every state other than an open read stream, reads return 1 on `dq_out`. This includes the read that completes the reset.
- R6: Sixteen consecutive writes without a read load an address, first bit most significant. Only the last 9 bits are kept. Completion pulses `addr_valid` with `addr`, and `rd_req` is raised for that address. A read before the sixteenth bit abandons the load.
- R7: After an address, each group of 8 reads returns the byte supplied on `rd_data` for the current address, most significant bit first.
- R8: After each read byte the address advances by one and `rd_req` is issued for it. The address wraps from 0x1FF to 0x000.
- R9: After an address, each group of 8 writes pulses `byte_valid` with the byte on `byte_out`, first bit in bit 7.
- R10: `start_nv` pulses when three conditions hold: at least one complete byte was loaded, a read ended the load with no partial byte pending, and that read is followed by a write of 1 and a read. A partial byte, or the same pattern outside a page load, produces no `start_nv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_n | input | 1 | Active-low select strobe from the bus |
| rd_en_n | input | 1 | Active-low read strobe |
| wr_en_n | input | 1 | Active-low write strobe |
| dq_in | input | 1 | Data bit from the pad |
| dq_out | output | 1 | Data bit to the pad |
| dq_oe | output | 1 | Pad output enable |
| illegal | output | 1 | Read and write asserted together under select |
| reset_evt | output | 1 | One-cycle pulse: reset command recognized |
| addr_valid | output | 1 | One-cycle pulse: serial address complete |
| addr | output | 9 | Current byte address |
| byte_valid | output | 1 | One-cycle pulse: written byte complete |
| byte_out | output | 8 | Last written byte |
| start_nv | output | 1 | One-cycle pulse: start nonvolatile write |
| rd_req | output | 1 | One-cycle request for the byte at `addr` |
| rd_ack | input | 1 | Read data valid |
| rd_data | input | 8 | Byte returned for the last request |

## Verification
The decoder is driven with clean reads and writes, with strobes that toggle while select is deasserted, and with overlapping read and write strobes. This shows which accesses count and which are ignored. Both command patterns are sent in several modes: idle, in the middle of a read stream, after full bytes and after a partial byte. A pattern that matches at the pin but should not fire is told apart from one that should. Reads at address 0x1FF separate a correct wrap from a carry into dropped bits. An illegal access in the middle of an address shows whether a discarded access really leaves the shift state untouched.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  // kind of the most recently completed bus access
  typedef enum logic [1:0] {CYC_NONE, CYC_RD, CYC_W0, CYC_W1} cyc_t;

  // protocol position
  typedef enum logic [2:0] {
    M_IDLE,   // reads return 1, a write starts an address
    M_ADDR,   // shifting address bits
    M_DATA,   // address loaded, direction not yet chosen
    M_READ,   // streaming bytes out
    M_LOAD,   // at least one byte loaded
    M_ENDED   // load closed by a read, awaiting write-1/read
  } mode_t;
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/ssp_cycle_class.sv
module ssp_cycle_class (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,      // synchronized, asserted high
  input  logic rd,
  input  logic wr,
  input  logic din,
  output logic rd_done,  // one-cycle pulse per completed read access
  output logic wr_done,  // one-cycle pulse per completed write access
  output logic wr_bit,   // bit captured by the completed write
  output logic illegal
);
  logic rd_act, wr_act, clash;
  logic rd_act_q, wr_act_q, spoil_q, bit_q;
  logic rd_fin, wr_fin, spoil_d, bit_d;

  assign clash  = sel & rd & wr;
  assign rd_act = sel & rd & ~wr;
  assign wr_act = sel & wr & ~rd;

  always_comb begin
    rd_fin  = rd_act_q & ~rd_act & ~clash & ~spoil_q;
    wr_fin  = wr_act_q & ~wr_act & ~clash & ~spoil_q;
    spoil_d = clash | (spoil_q & sel);   // held until select releases
    bit_d   = wr_act ? din : bit_q;      // last value seen before release
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act_q <= 1'b0;
      wr_act_q <= 1'b0;
      spoil_q  <= 1'b0;
      bit_q    <= 1'b0;
      rd_done  <= 1'b0;
      wr_done  <= 1'b0;
      wr_bit   <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      rd_act_q <= rd_act;
      wr_act_q <= wr_act;
      spoil_q  <= spoil_d;
      bit_q    <= bit_d;
      rd_done  <= rd_fin;
      wr_done  <= wr_fin;
      wr_bit   <= bit_q;
      illegal  <= clash;
    end
  end

  assert_one_kind_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_done, wr_done}));
endmodule

// File: rtl/ssp_seq.sv
module ssp_seq
  import ssp_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int BYTE_W   = 8,
  parameter int SEQ_BITS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_done,
  input  logic              wr_done,
  input  logic              wr_bit,
  input  logic              rd_ack,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              dq_out,
  output logic              reset_evt,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_out,
  output logic              start_nv,
  output logic              rd_req
);
  localparam int CNT_W = $clog2(SEQ_BITS);
  localparam logic [CNT_W-1:0] SEQ_LAST  = CNT_W'(SEQ_BITS - 1);
  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(BYTE_W - 1);

  mode_t             mode_q, mode_d;
  cyc_t              hist1_q, hist1_d, hist2_q, hist2_d, kind;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] asr_q, asr_d, addr_q, addr_d, asr_shift;
  logic [BYTE_W-1:0] isr_q, isr_d, osr_q, osr_d, isr_shift, byte_q, byte_d;
  logic              rst_d, av_d, bv_d, nv_d, req_d;

  assign asr_shift = {asr_q[ADDR_W-2:0], wr_bit};
  assign isr_shift = {isr_q[BYTE_W-2:0], wr_bit};
  assign kind = rd_done ? CYC_RD : (wr_done ? (wr_bit ? CYC_W1 : CYC_W0) : CYC_NONE);

  always_comb begin
    mode_d = mode_q;  cnt_d = cnt_q;  hist1_d = hist1_q;  hist2_d = hist2_q;
    asr_d = asr_q;  addr_d = addr_q;  isr_d = isr_q;  osr_d = osr_q;  byte_d = byte_q;
    rst_d = 1'b0;  av_d = 1'b0;  bv_d = 1'b0;  nv_d = 1'b0;  req_d = 1'b0;
    if (rd_ack) osr_d = rd_data;
    if (rd_done || wr_done) begin
      hist2_d = hist1_q;
      hist1_d = kind;
    end
    if (rd_done) begin
      if (hist2_q == CYC_RD && hist1_q == CYC_W0) begin
        rst_d = 1'b1;  mode_d = M_IDLE;  cnt_d = '0;
      end else if (mode_q == M_ENDED && hist2_q == CYC_RD && hist1_q == CYC_W1) begin
        nv_d = 1'b1;  mode_d = M_IDLE;  cnt_d = '0;
      end else begin
        case (mode_q)
          M_DATA, M_READ: begin
            if (mode_q == M_DATA && cnt_q != '0) begin
              mode_d = M_IDLE;  cnt_d = '0;      // partial byte then read
            end else begin
              mode_d = M_READ;
              osr_d  = {osr_q[BYTE_W-2:0], 1'b1};
              if (cnt_q == BYTE_LAST) begin
                cnt_d  = '0;
                addr_d = addr_q + ADDR_W'(1);
                req_d  = 1'b1;
              end else begin
                cnt_d = cnt_q + CNT_W'(1);
              end
            end
          end
          M_LOAD: begin
            mode_d = (cnt_q == '0) ? M_ENDED : M_IDLE;
            cnt_d  = '0;
          end
          default: begin
            mode_d = M_IDLE;  cnt_d = '0;
          end
        endcase
      end
    end else if (wr_done) begin
      case (mode_q)
        M_IDLE, M_READ: begin
          asr_d = asr_shift;  cnt_d = CNT_W'(1);  mode_d = M_ADDR;
        end
        M_ADDR: begin
          asr_d = asr_shift;
          if (cnt_q == SEQ_LAST) begin
            addr_d = asr_shift;  av_d = 1'b1;  req_d = 1'b1;
            mode_d = M_DATA;  cnt_d = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        M_DATA, M_LOAD: begin
          isr_d = isr_shift;
          if (cnt_q == BYTE_LAST) begin
            byte_d = isr_shift;  bv_d = 1'b1;  cnt_d = '0;  mode_d = M_LOAD;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_IDLE;  cnt_q <= '0;  hist1_q <= CYC_NONE;  hist2_q <= CYC_NONE;
      asr_q <= '0;  addr_q <= '0;  isr_q <= '0;  osr_q <= '1;  byte_q <= '0;
      reset_evt <= 1'b0;  addr_valid <= 1'b0;  byte_valid <= 1'b0;
      start_nv <= 1'b0;  rd_req <= 1'b0;
    end else begin
      mode_q <= mode_d;  cnt_q <= cnt_d;  hist1_q <= hist1_d;  hist2_q <= hist2_d;
      asr_q <= asr_d;  addr_q <= addr_d;  isr_q <= isr_d;  osr_q <= osr_d;  byte_q <= byte_d;
      reset_evt <= rst_d;  addr_valid <= av_d;  byte_valid <= bv_d;
      start_nv <= nv_d;  rd_req <= req_d;
    end
  end

  assign addr     = addr_q;
  assign byte_out = byte_q;
  assign dq_out   = (mode_q == M_DATA || mode_q == M_READ) ? osr_q[BYTE_W-1] : 1'b1;

  assert_reset_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reset_evt |-> $past(rd_done));
  assert_reset_reads_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reset_evt |=> dq_out);
  assert_addr_byte_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> !byte_valid);
  assert_byte_from_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(wr_done));
  assert_nv_from_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_nv |-> $past(rd_done));
endmodule

// File: rtl/strobe_serial_port.sv
module strobe_serial_port #(
  parameter int ADDR_W      = 9,
  parameter int BYTE_W      = 8,
  parameter int SEQ_BITS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_n,
  input  logic              rd_en_n,
  input  logic              wr_en_n,
  input  logic              dq_in,
  output logic              dq_out,
  output logic              dq_oe,
  output logic              illegal,
  output logic              reset_evt,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_out,
  output logic              start_nv,
  output logic              rd_req,
  input  logic              rd_ack,
  input  logic [BYTE_W-1:0] rd_data
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic [3:0] pins_s;
  logic       s_sel, s_rd, s_wr, s_dq;
  logic       rd_done, wr_done, wr_bit;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ssp_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n),
    .d({~bus_sel_n, ~rd_en_n, ~wr_en_n, dq_in}),
    .q(pins_s)
  );
  assign {s_sel, s_rd, s_wr, s_dq} = pins_s;

  ssp_cycle_class u_class (
    .clk(clk), .rst_n(rst_int_n),
    .sel(s_sel), .rd(s_rd), .wr(s_wr), .din(s_dq),
    .rd_done(rd_done), .wr_done(wr_done), .wr_bit(wr_bit), .illegal(illegal)
  );

  ssp_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .SEQ_BITS(SEQ_BITS)) u_seq (
    .clk(clk), .rst_n(rst_int_n),
    .rd_done(rd_done), .wr_done(wr_done), .wr_bit(wr_bit),
    .rd_ack(rd_ack), .rd_data(rd_data),
    .dq_out(dq_out), .reset_evt(reset_evt), .addr_valid(addr_valid), .addr(addr),
    .byte_valid(byte_valid), .byte_out(byte_out), .start_nv(start_nv), .rd_req(rd_req)
  );

  assign dq_oe = s_sel & s_rd;
endmodule

// File: tb/strobe_serial_port_tb_top.sv
`timescale 1ns/1ps
module strobe_serial_port_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, bus_sel_n, rd_en_n, wr_en_n, dq_in;
  logic dq_out, dq_oe, illegal, reset_evt, addr_valid, byte_valid, start_nv, rd_req;
  logic [8:0] addr;
  logic [7:0] byte_out, rd_data;
  logic rd_ack;

  strobe_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel_n(bus_sel_n), .rd_en_n(rd_en_n),
    .wr_en_n(wr_en_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .illegal(illegal), .reset_evt(reset_evt), .addr_valid(addr_valid), .addr(addr),
    .byte_valid(byte_valid), .byte_out(byte_out), .start_nv(start_nv),
    .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data)
  );

  int errors = 0, checks = 0;
  int n_rst = 0, n_av = 0, n_bv = 0, n_nv = 0;
  logic [8:0] seen_addr = '0, req_addr = '0;
  logic [7:0] last_byte = '0, prev_byte = '0;
  bit done_flag = 1'b0;

  function automatic logic [7:0] memf(input logic [8:0] a);
    return a[7:0] ^ 8'h3C ^ {7'b0, a[8]};
  endfunction

  // memory model and event monitors
  always @(posedge clk) begin
    rd_ack <= rd_req;
    if (rd_req) begin rd_data <= memf(addr); req_addr <= addr; end
    if (reset_evt) n_rst <= n_rst + 1;
    if (addr_valid) begin n_av <= n_av + 1; seen_addr <= addr; end
    if (byte_valid) begin n_bv <= n_bv + 1; prev_byte <= last_byte; last_byte <= byte_out; end
    if (start_nv) n_nv <= n_nv + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wbit(input logic b);
    dq_in = b; bus_sel_n = 1'b0; tick(2);
    wr_en_n = 1'b0; tick(4); wr_en_n = 1'b1; tick(2);
    bus_sel_n = 1'b1; tick(4);
  endtask

  task automatic rbit(output logic b, output logic oe);
    bus_sel_n = 1'b0; tick(2);
    rd_en_n = 1'b0; tick(5); b = dq_out; oe = dq_oe;
    rd_en_n = 1'b1; tick(2); bus_sel_n = 1'b1; tick(4);
  endtask

  task automatic rskip();
    logic b, oe;
    rbit(b, oe);
  endtask

  task automatic cmd_reset();
    rskip(); wbit(1'b0); rskip();
  endtask

  task automatic send_addr(input logic [15:0] a);
    for (int i = 15; i >= 0; i--) wbit(a[i]);
  endtask

  task automatic read_byte(output logic [7:0] v);
    logic oe;
    for (int i = 7; i >= 0; i--) rbit(v[i], oe);
  endtask

  task automatic write_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) wbit(v[i]);
  endtask

  task automatic t_reset_state();
    check("R2 oe idle after reset", dq_oe, 0);
    check("R3 illegal idle after reset", illegal, 0);
    check("R5 dq_out idle value", dq_out, 1);
    check("R1 no events after reset", n_rst + n_av + n_bv + n_nv, 0);
  endtask

  task automatic t_reset_cmd();
    int r0 = n_rst; logic b, oe;
    cmd_reset();
    check("R4 reset pulse count", n_rst, r0 + 1);
    rbit(b, oe);
    check("R5 read after reset returns 1", b, 1);
    check("R2 oe during read", oe, 1);
    check("R2 oe after read", dq_oe, 0);
  endtask

  task automatic t_no_select();
    int a0 = n_av;
    for (int i = 0; i < 20; i++) begin
      wr_en_n = 1'b0; tick(3); wr_en_n = 1'b1; tick(3);
    end
    check("R1 writes without select ignored", n_av, a0);
    rd_en_n = 1'b0; tick(4);
    check("R2 oe low without select", dq_oe, 0);
    rd_en_n = 1'b1; tick(4);
  endtask

  task automatic t_read_stream();
    int a0; logic [7:0] v;
    cmd_reset(); a0 = n_av;
    send_addr(16'hFE00 | 16'h00A5);
    check("R6 address pulse", n_av, a0 + 1);
    check("R6 low 9 bits kept", seen_addr, 9'h0A5);
    check("R6 request address", req_addr, 9'h0A5);
    read_byte(v);
    check("R7 first byte", v, memf(9'h0A5));
    read_byte(v);
    check("R8 next byte", v, memf(9'h0A6));
  endtask

  task automatic t_wrap();
    logic [7:0] v;
    cmd_reset(); send_addr(16'h01FF);
    read_byte(v);
    check("R7 byte at top", v, memf(9'h1FF));
    check("R8 wrapped request", req_addr, 0);
    read_byte(v);
    check("R8 byte after wrap", v, memf(9'h000));
  endtask

  task automatic t_abort_read();
    int r0 = n_rst; logic b, oe;
    rskip(); rskip();
    cmd_reset();
    check("R4 reset inside read stream", n_rst, r0 + 1);
    rbit(b, oe);
    check("R5 read after abort returns 1", b, 1);
  endtask

  task automatic t_page_load();
    int b0, v0;
    cmd_reset(); send_addr(16'h0010);
    b0 = n_bv; v0 = n_nv;
    write_byte(8'hA7); write_byte(8'h3C);
    check("R9 byte pulses", n_bv, b0 + 2);
    check("R9 first byte", prev_byte, 8'hA7);
    check("R9 second byte", last_byte, 8'h3C);
    rskip(); wbit(1'b1); rskip();
    check("R10 start pulse", n_nv, v0 + 1);
  endtask

  task automatic t_partial();
    int b0, v0;
    cmd_reset(); send_addr(16'h0020);
    b0 = n_bv; v0 = n_nv;
    write_byte(8'h55); wbit(1'b1); wbit(1'b0); wbit(1'b1);
    rskip(); wbit(1'b1); rskip();
    check("R9 one full byte only", n_bv, b0 + 1);
    check("R10 no start after partial byte", n_nv, v0);
  endtask

  task automatic t_nv_outside_load();
    int v0;
    cmd_reset(); send_addr(16'h0030); v0 = n_nv;
    rskip(); wbit(1'b1); rskip();
    check("R10 no start from read stream", n_nv, v0);
  endtask

  task automatic t_illegal();
    int a0;
    cmd_reset(); a0 = n_av;
    for (int i = 15; i >= 8; i--) wbit(1'(16'h0123 >> i));
    bus_sel_n = 1'b0; tick(2);
    wr_en_n = 1'b0; rd_en_n = 1'b0; tick(4);
    check("R3 illegal flagged", illegal, 1);
    rd_en_n = 1'b1; wr_en_n = 1'b1; tick(2); bus_sel_n = 1'b1; tick(4);
    check("R3 illegal cleared", illegal, 0);
    for (int i = 7; i >= 0; i--) wbit(1'(16'h0123 >> i));
    check("R3 illegal access not shifted", seen_addr, 9'h123);
    check("R3 one address only", n_av, a0 + 1);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_sel_n = 1'b1; rd_en_n = 1'b1; wr_en_n = 1'b1; dq_in = 1'b0;
    tick(4); rst_n = 1'b1; tick(6);
    t_reset_state();
    t_reset_cmd();
    t_no_select();
    t_read_stream();
    t_wrap();
    t_abort_read();
    t_page_load();
    t_partial();
    t_nv_outside_load();
    t_illegal();
    finish_run();
  end
endmodule